// File: doc/BRIEF.md
# Programmable AND-Plane Product-Term Evaluator

This block is the AND plane of a small programmable logic array. Eight dedicated inputs and eight feedback (or pin) signals are expanded into 32 literal lines, one true and one inverted line per signal. Sixty-four product terms each AND together whichever of those lines their connection mask selects. The result is a 64-bit product-term vector that a downstream OR plane and its output cells consume. The connection masks sit in ordinary registers and are loaded one row at a time. A single strobe opens every connection at once.

The terms form eight groups of eight. Within each group, terms 0 to 6 serve the sum-of-products logic. Term 7 is the spare term that an output cell may use for an extra product or for output-enable control. The plane does not tell these roles apart: it evaluates every row the same way, and the position of a row in the output vector carries its role.

Top module: `pterm_and_plane`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every connection mask is cleared, so from the next edge until a row is written `term_out` reads all ones for any inputs.
- R2: Signal s (s = 0..7 is `ded_in[s]`, s = 8..15 is `fb_in[s-8]`) drives literal line 2s with its true value and line 2s+1 with its inverse. Bit k of a connection mask connects line k.
- R3: Each product term is 1 exactly when every line selected by its mask is 1.
- R4: A row whose mask is all zeros reads 1 for every input pattern.
- R5: A row that connects both line 2s and line 2s+1 of any signal reads 0 for every input pattern.
- R6: With `wr_en` high and `erase` low at a rising edge, the mask of row `wr_row` becomes `wr_mask` at that edge. The output does not change before the edge, and every other row keeps its mask.
- R7: With `erase` high at a rising edge, every mask becomes all zeros at that edge, even when `wr_en` is high in the same cycle.
- R8: Row address `wr_row` equals the bit index in `term_out`, which is group*8 + term. Term 7 of each group is the auxiliary term.
- R9: `term_out` follows `ded_in` and `fb_in` combinationally, with no clock edge between an input change and the output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mask registers |
| rst_n | input | 1 | Synchronous active-low reset; clears all masks |
| ded_in | input | 8 | Dedicated input signals |
| fb_in | input | 8 | Feedback or pin input signals |
| wr_en | input | 1 | Write one mask row at the next edge |
| wr_row | input | 6 | Row to write; equals the output bit index |
| wr_mask | input | 32 | Connection mask for the written row, bit k selects line k |
| erase | input | 1 | Open every connection at the next edge; wins over a write |
| term_out | output | 64 | Product-term vector, bit group*8+term |

## Verification
Each literal line is connected alone in row 0, and the row is compared against the line's computed value under several patterns. This shows the true/inverse pairing and the signal numbering apart from any AND behaviour. All 64 rows are then loaded with distinct two- and three-literal masks and swept over all 256 dedicated-input values, with the feedback bits derived from each value. This separates correct AND evaluation and row placement from swapped or shifted rows. An open row and a self-contradicting row are swept over all 65,536 input combinations, which pins down the two forced constant cases. Write timing, erase-over-write priority, mid-run reset and the auxiliary-term positions are each probed on both sides of the deciding clock edge.

// File: rtl/pterm_pkg.sv
// pterm_pkg
// Shared types for the product-term AND plane.
// Assumes: consumed by the mask store and the top level only.
package pterm_pkg;

    // Operation the mask store applies at the next clock edge.
    typedef enum logic [1:0] {
        STORE_HOLD  = 2'd0,
        STORE_WRITE = 2'd1,
        STORE_ERASE = 2'd2
    } store_op_e;

endpackage

// File: rtl/pterm_line_builder.sv
// pterm_line_builder
// Expands the dedicated and feedback signals into literal lines: signal s
// drives line 2s true and line 2s+1 inverted. Signals 0..N_DED-1 are the
// dedicated inputs, the remaining ones the feedback inputs.
// Assumes: purely combinational, no clock.
module pterm_line_builder #(
    parameter int N_DED = 8,
    parameter int N_FB  = 8,
    localparam int N_SIG   = N_DED + N_FB,
    localparam int N_LINES = 2 * N_SIG
) (
    input  logic [N_DED-1:0]   ded_in,
    input  logic [N_FB-1:0]    fb_in,
    output logic [N_LINES-1:0] lines
);

    logic [N_SIG-1:0] sig_all;

    // Concatenate the signal sources in numbering order.
    always_comb sig_all = {fb_in, ded_in};

    for (genvar s = 0; s < N_SIG; s++) begin : g_sig
        // True literal on the even line, inverse on the odd line.
        always_comb begin
            lines[2*s]     = sig_all[s];
            lines[2*s + 1] = ~sig_all[s];
        end
    end

endmodule

// File: rtl/pterm_mask_store.sv
// pterm_mask_store
// Register file of connection masks, one row per product term. One row is
// written per cycle; an erase clears every row and wins over a write.
// Assumes: synchronous active-low reset clears all rows (all connections
// open). Out-of-range row addresses are ignored.
module pterm_mask_store
    import pterm_pkg::*;
#(
    parameter int N_TERMS = 64,
    parameter int N_LINES = 32,
    localparam int ROW_W  = $clog2(N_TERMS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ROW_W-1:0]                wr_row,
    input  logic [N_LINES-1:0]              wr_mask,
    input  logic                            erase,
    output logic [N_TERMS-1:0][N_LINES-1:0] masks
);

    store_op_e op;
    logic      row_ok;

    // Address range check, only built when the row count is not a power of two.
    if (N_TERMS == (2 ** ROW_W)) begin : g_full_range
        always_comb row_ok = 1'b1;
    end else begin : g_part_range
        localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(N_TERMS - 1);
        always_comb row_ok = (wr_row <= LAST_ROW);
    end

    // Decode this cycle's operation; erase has priority over a write.
    always_comb begin
        if (erase)
            op = STORE_ERASE;
        else if (wr_en && row_ok)
            op = STORE_WRITE;
        else
            op = STORE_HOLD;
    end

    for (genvar r = 0; r < N_TERMS; r++) begin : g_row
        // Update one row: reset or erase open it, a matching write loads it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                masks[r] <= '0;
            else if (op == STORE_ERASE)
                masks[r] <= '0;
            else if (op == STORE_WRITE && wr_row == ROW_W'(r))
                masks[r] <= wr_mask;
        end

        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !erase && wr_row == ROW_W'(r)) |=> (masks[r] == $past(wr_mask))); // R6

        AST_OTHER_ROWS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!erase && !(wr_en && wr_row == ROW_W'(r))) |=> $stable(masks[r])); // R6
    end

    AST_ERASE_OPENS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (masks == '0)); // R7

    AST_RESET_OPENS_ALL: assert property (@(posedge clk)
        !rst_n |=> (masks == '0)); // R1

endmodule

// File: rtl/pterm_and_row.sv
// pterm_and_row
// One product term: AND of the literal lines whose mask bit is set. An
// unselected line is forced to 1, so an empty mask yields 1 and a mask
// holding both polarities of one signal yields 0.
// Assumes: combinational, one instance per term.
module pterm_and_row #(
    parameter int N_LINES = 32
) (
    input  logic [N_LINES-1:0] lines,
    input  logic [N_LINES-1:0] mask,
    output logic               term
);

    // Mask off unconnected lines, then reduce.
    always_comb term = &(lines | ~mask);

endmodule

// File: rtl/pterm_and_plane.sv
// pterm_and_plane
// Top of the programmable AND plane: builds the literal lines, holds the
// connection masks, and evaluates N_GRP groups of GRP_TERMS product terms.
// Output bit group*GRP_TERMS + term; the last term of each group is the
// auxiliary term. Output is combinational from inputs and stored masks.
// Assumes: synchronous active-low reset; row address equals output index.
module pterm_and_plane #(
    parameter int N_DED     = 8,
    parameter int N_FB      = 8,
    parameter int N_GRP     = 8,
    parameter int GRP_TERMS = 8,
    localparam int N_SIG    = N_DED + N_FB,
    localparam int N_LINES  = 2 * N_SIG,
    localparam int N_TERMS  = N_GRP * GRP_TERMS,
    localparam int ROW_W    = $clog2(N_TERMS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_DED-1:0]   ded_in,
    input  logic [N_FB-1:0]    fb_in,
    input  logic               wr_en,
    input  logic [ROW_W-1:0]   wr_row,
    input  logic [N_LINES-1:0] wr_mask,
    input  logic               erase,
    output logic [N_TERMS-1:0] term_out
);

    logic [N_LINES-1:0]              lines;
    logic [N_TERMS-1:0][N_LINES-1:0] masks;

    // Literal line expansion.
    pterm_line_builder #(
        .N_DED (N_DED),
        .N_FB  (N_FB)
    ) u_lines (
        .ded_in (ded_in),
        .fb_in  (fb_in),
        .lines  (lines)
    );

    // Connection mask registers.
    pterm_mask_store #(
        .N_TERMS (N_TERMS),
        .N_LINES (N_LINES)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_mask (wr_mask),
        .erase   (erase),
        .masks   (masks)
    );

    // Product-term array, laid out group by group.
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        for (genvar t = 0; t < GRP_TERMS; t++) begin : g_term
            localparam int IDX = g * GRP_TERMS + t;
            pterm_and_row #(
                .N_LINES (N_LINES)
            ) u_row (
                .lines (lines),
                .mask  (masks[IDX]),
                .term  (term_out[IDX])
            );
        end
    end

    // True when a mask selects both polarities of any one signal.
    function automatic logic has_pair(input logic [N_LINES-1:0] m);
        logic hit = 1'b0;
        for (int s = 0; s < N_SIG; s++)
            hit |= m[2*s] & m[2*s + 1];
        return hit;
    endfunction

    for (genvar i = 0; i < N_TERMS; i++) begin : g_chk
        AST_OPEN_ROW_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
            (masks[i] == '0) |-> term_out[i]); // R4

        AST_PAIR_ROW_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
            has_pair(masks[i]) |-> !term_out[i]); // R5
    end

    for (genvar s = 0; s < N_SIG; s++) begin : g_line_chk
        AST_LINE_PAIR_OPPOSED: assert property (@(posedge clk) disable iff (!rst_n)
            lines[2*s + 1] != lines[2*s]); // R2
    end

endmodule

// File: tb/pterm_and_plane_tb.sv
// pterm_and_plane_tb
// Self-checking bench: keeps its own mask model, computes every expected
// term from the literal-line definition, and sweeps inputs exhaustively
// where the space is small.
module pterm_and_plane_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  ded_in;
    logic [7:0]  fb_in;
    logic        wr_en;
    logic [5:0]  wr_row;
    logic [31:0] wr_mask;
    logic        erase;
    logic [63:0] term_out;

    int checks   = 0;
    int failures = 0;
    logic [31:0] mdl [64];

    always #4 clk = ~clk;

    pterm_and_plane u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ded_in   (ded_in),
        .fb_in    (fb_in),
        .wr_en    (wr_en),
        .wr_row   (wr_row),
        .wr_mask  (wr_mask),
        .erase    (erase),
        .term_out (term_out)
    );

    // Value of literal line l for given inputs.
    function automatic logic line_val(int l, logic [7:0] d, logic [7:0] f);
        int s = l / 2;
        logic v = (s < 8) ? d[s] : f[s-8];
        return (l % 2 == 1) ? ~v : v;
    endfunction

    // Expected term vector from the bench mask model.
    function automatic logic [63:0] model_out(logic [7:0] d, logic [7:0] f);
        logic [63:0] e;
        for (int r = 0; r < 64; r++) begin
            e[r] = 1'b1;
            for (int l = 0; l < 32; l++)
                if (mdl[r][l] && !line_val(l, d, f)) e[r] = 1'b0;
        end
        return e;
    endfunction

    function automatic logic [31:0] mask_of(int r);
        logic [31:0] m = (32'd1 << (r % 32)) | (32'd1 << ((r * 7 + 3) % 32));
        if (r >= 32) m |= 32'd1 << ((r * 13 + 1) % 32);
        if (r == 5)  m = 32'd0;
        if (r == 63) m = 32'h0000_0030;
        return m;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_row(int r, logic [31:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 6'(r); wr_mask = m;
        @(negedge clk);
        wr_en = 1'b0;
        mdl[r] = m;
    endtask

    task automatic do_erase();
        @(negedge clk);
        erase = 1'b1;
        @(negedge clk);
        erase = 1'b0;
        for (int r = 0; r < 64; r++) mdl[r] = '0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; ded_in = '0; fb_in = '0;
        wr_en = 1'b0; wr_row = '0; wr_mask = '0; erase = 1'b0;
        for (int r = 0; r < 64; r++) mdl[r] = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset open", term_out, {64{1'b1}});
        rst_n = 1'b1;
        ded_in = 8'h3C; fb_in = 8'hA5; #1;
        chk("R1 open after reset", term_out, {64{1'b1}});

        // R2 and R3: each literal alone in row 0, several patterns.
        for (int l = 0; l < 32; l++) begin
            write_row(0, 32'd1 << l);
            for (int p = 0; p < 8; p++) begin
                ded_in = 8'(p * 37 + l);
                fb_in  = 8'(p * 91) ^ 8'(l * 5);
                #1;
                chk("R2 single literal", term_out, model_out(ded_in, fb_in));
                chk("R3 single literal bit", {63'd0, term_out[0]},
                    {63'd0, line_val(l, ded_in, fb_in)});
            end
        end
        do_erase();
        #1;
        chk("R7 erase from loaded", term_out, {64{1'b1}});

        // R6: write visible only after the edge; other rows unchanged.
        ded_in = 8'h00; fb_in = 8'h00;
        @(negedge clk);
        wr_en = 1'b1; wr_row = 6'd10; wr_mask = 32'h1;
        #2;
        chk("R6 before edge", term_out, {64{1'b1}});
        @(posedge clk); #1;
        wr_en = 1'b0;
        mdl[10] = 32'h1;
        chk("R6 after edge", term_out, ~(64'd1 << 10));

        // R3 and R8: all rows programmed, full sweep of dedicated inputs.
        for (int r = 0; r < 64; r++) write_row(r, mask_of(r));
        for (int d = 0; d < 256; d++) begin
            ded_in = 8'(d);
            fb_in  = 8'(d * 3 + 1);
            #1;
            chk("R3 full plane", term_out, model_out(ded_in, fb_in));
        end

        // R4 and R5: open row and contradicting row over every input.
        for (int v = 0; v < 65536; v++) begin
            ded_in = v[7:0];
            fb_in  = v[15:8];
            #1;
            chk("R4 open row", {63'd0, term_out[5]}, 64'd1);
            chk("R5 paired row", {63'd0, term_out[63]}, 64'd0);
        end

        // R9: input change inside one clock phase reaches the output.
        @(negedge clk);
        ded_in = 8'h11; fb_in = 8'h22; #1;
        chk("R9 pattern A", term_out, model_out(ded_in, fb_in));
        ded_in = 8'hEE; fb_in = 8'hDD; #1;
        chk("R9 pattern B", term_out, model_out(ded_in, fb_in));

        // R8: auxiliary term of group g tests ded_in[g] true.
        do_erase();
        for (int g = 0; g < 8; g++) write_row(g * 8 + 7, 32'd1 << (2 * g));
        ded_in = 8'b1010_0101; fb_in = 8'h00; #1;
        begin
            logic [63:0] exp_aux = {64{1'b1}};
            for (int g = 0; g < 8; g++)
                if (!ded_in[g]) exp_aux[g * 8 + 7] = 1'b0;
            chk("R8 aux positions", term_out, exp_aux);
        end

        // R7: erase and write together; erase must win.
        do_erase();
        ded_in = 8'h00;
        @(negedge clk);
        erase = 1'b1; wr_en = 1'b1; wr_row = 6'd3; wr_mask = 32'h1;
        @(negedge clk);
        erase = 1'b0; wr_en = 1'b0;
        chk("R7 erase beats write", term_out, {64{1'b1}});

        // R1: reset in mid-run clears a loaded row.
        write_row(0, 32'h1);
        chk("R1 loaded before reset", term_out, ~64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mid-run reset", term_out, {64{1'b1}});

        finish_run();
    end

endmodule